// File: doc/BRIEF.md
# Frequency-Window Lock Detector

This block decides whether a clock recovery loop is following valid serial data. It divides the recovered clock down to the reference rate and counts the result in its own clock domain with a gray-coded counter. That count is carried into the reference domain through a two-flop synchronizer. Over a fixed window of reference cycles, the block compares the number of recovered ticks with the window length. Agreement within a small tolerance, about 100 ppm of the default 32768-cycle window, counts as a passing window.

While out of lock, the block keeps the loop trained on the local reference. It runs a repeating poll: several reference-training windows, then one window on the data input. A passing data window starts confirmation. A second consecutive pass declares lock. Any failing window while steered to data returns the loop to the reference. An active-low force input overrides the frequency check and keeps the loop on the reference. A rate select tells the block whether the reference runs at the full or the half rate, which sets the recovered-clock divide ratio.

Top module: `freq_lock_monitor`

## Requirements
- R1: While `rst_n` is low, and in the first window after reset, `lock` is 0 and `trk_data` is 0.
- R2: With `rate_half`=0 the recovered clock is divided by 10, and with `rate_half`=1 by 20. A recovered clock 10x (or 20x) the reference therefore passes. A divide setting that does not match the clocks fails.
- R3: A window lasts 2^`WIN_LOG2` reference cycles. It passes when the divided recovered-tick count in it is within `TOL` (default 3) of 2^`WIN_LOG2`, and fails otherwise. For example, 255 ticks in a 256-cycle window pass and 251 fail.
- R4: `lock` rises only after two consecutive passing windows taken with `trk_data`=1.
- R5: A single failing window taken while `trk_data`=1 drops `lock` and returns `trk_data` to 0 for the next window.
- R6: While out of lock, `trk_data` is 0 for `POLL_REF` (default 4) windows and then 1 for one probe window. A failed probe repeats this cycle.
- R7: While `force_ref_n` is 0, `lock` and `trk_data` are 0 at once. The poll state is held at its start, so training resumes from the beginning after release.
- R8: The recovered-tick count crosses into the reference domain as a gray code that changes by at most one bit per recovered-domain clock.
- R9: Apart from the force input, `lock` and `trk_data` change only at window ends and are constant inside a window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Local reference clock; all decisions are made in this domain |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| rcv_clk | input | 1 | Recovered clock before division |
| rate_half | input | 1 | 0: reference at full rate (divide by 10); 1: half rate (divide by 20) |
| force_ref_n | input | 1 | Active low: keep the loop on the reference regardless of frequency |
| lock | output | 1 | 1 when the recovered frequency has been confirmed within tolerance |
| trk_data | output | 1 | Loop steering: 1 = track the data input, 0 = train on the reference |

## Verification
A window's verdict reaches the outputs about three reference cycles after the nominal window boundary. This delay comes from the synchronizer lag, the snapshot register and the control register. The effect of `force_ref_n` on the outputs is immediate. The bench changes frequency, divide setting and force about two cycles before each boundary, so each stimulus belongs to exactly one window. It reads both outputs at the quarter and three-quarter points of every window, where the verdict of the previous window has settled and no new one can be due. A reference model in the bench steps once per window to predict the value at each sampling point.

// File: rtl/flm_pkg.sv
`timescale 1ns/1ps
package flm_pkg;
  typedef enum logic [1:0] {
    ST_TRAIN   = 2'd0,
    ST_PROBE   = 2'd1,
    ST_CONFIRM = 2'd2,
    ST_LOCK    = 2'd3
  } flm_state_e;
endpackage

// File: rtl/flm_rst_sync.sv
`timescale 1ns/1ps
module flm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/flm_tick_cnt.sv
`timescale 1ns/1ps
module flm_tick_cnt #(
  parameter int CW       = 17,
  parameter int DIV_FULL = 10,
  parameter int DIV_HALF = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rate_half,
  output logic [CW-1:0] gray_o
);
  localparam int DMAX = (DIV_FULL > DIV_HALF) ? DIV_FULL : DIV_HALF;
  localparam int DW   = $clog2(DMAX);
  localparam logic [DW-1:0] LIM_FULL = DW'(DIV_FULL - 1);
  localparam logic [DW-1:0] LIM_HALF = DW'(DIV_HALF - 1);
  localparam logic [DW-1:0] LIM_MAX  = DW'(DMAX - 1);

  logic          half_meta_q, half_q;
  logic [DW-1:0] div_q, div_d, lim;
  logic [CW-1:0] bin_q, bin_d, gray_q, gray_d;
  logic          tick;

  always_comb begin
    lim    = half_q ? LIM_HALF : LIM_FULL;
    tick   = (div_q >= lim);
    div_d  = tick ? '0 : div_q + 1'b1;
    bin_d  = bin_q + CW'(tick);
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_meta_q <= 1'b0;
      half_q      <= 1'b0;
      div_q       <= '0;
      bin_q       <= '0;
      gray_q      <= '0;
    end else begin
      half_meta_q <= rate_half;
      half_q      <= half_meta_q;
      div_q       <= div_d;
      bin_q       <= bin_d;
      gray_q      <= gray_d;
    end
  end

  assign gray_o = gray_q;

  AST_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gray_q ^ $past(gray_q))); // R8
  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= LIM_MAX); // R2
endmodule

// File: rtl/flm_gray_sync.sv
`timescale 1ns/1ps
module flm_gray_sync #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] gray_i,
  output logic [CW-1:0] bin_o
);
  logic [CW-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_i;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    bin_o[CW-1] = sync_q[CW-1];
    for (int i = CW - 2; i >= 0; i--) begin
      bin_o[i] = bin_o[i+1] ^ sync_q[i];
    end
  end
endmodule

// File: rtl/flm_window.sv
`timescale 1ns/1ps
module flm_window #(
  parameter int WIN_LOG2 = 15,
  parameter int TOL      = 3,
  parameter int CW       = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  output logic          done_o,
  output logic          pass_o
);
  localparam int WIN = 1 << WIN_LOG2;
  localparam logic [CW-1:0] BAND_LO = CW'(WIN - TOL);
  localparam logic [CW-1:0] BAND_HI = CW'(WIN + TOL);

  logic [WIN_LOG2-1:0] wcnt_q, wcnt_d;
  logic [CW-1:0]       prev_q, prev_d, diff;
  logic                done_q, done_d, pass_q, pass_d;
  logic                win_end, in_band;

  always_comb begin
    win_end = &wcnt_q;
    wcnt_d  = wcnt_q + 1'b1;
    diff    = cnt_i - prev_q;
    in_band = (diff >= BAND_LO) && (diff <= BAND_HI);
    prev_d  = win_end ? cnt_i : prev_q;
    done_d  = win_end;
    pass_d  = win_end ? in_band : pass_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      prev_q <= '0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      wcnt_q <= wcnt_d;
      prev_q <= prev_d;
      done_q <= done_d;
      pass_q <= pass_d;
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;

  AST_DONE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (wcnt_q == '0)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R3
endmodule

// File: rtl/flm_ctrl.sv
`timescale 1ns/1ps
module flm_ctrl
  import flm_pkg::*;
#(
  parameter int POLL_REF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic force_ref_n,
  input  logic done_i,
  input  logic pass_i,
  output logic lock_o,
  output logic trk_o
);
  localparam int PW = (POLL_REF > 1) ? $clog2(POLL_REF) : 1;
  localparam logic [PW-1:0] PC_LAST = PW'(POLL_REF - 1);

  flm_state_e    st_q, st_d;
  logic [PW-1:0] pc_q, pc_d;

  always_comb begin
    st_d = st_q;
    pc_d = pc_q;
    if (!force_ref_n) begin
      st_d = ST_TRAIN;
      pc_d = '0;
    end else if (done_i) begin
      case (st_q)
        ST_TRAIN: begin
          if (pc_q == PC_LAST) begin
            st_d = ST_PROBE;
            pc_d = '0;
          end else begin
            pc_d = pc_q + 1'b1;
          end
        end
        ST_PROBE:   st_d = pass_i ? ST_CONFIRM : ST_TRAIN;
        ST_CONFIRM: st_d = pass_i ? ST_LOCK    : ST_TRAIN;
        ST_LOCK:    st_d = pass_i ? ST_LOCK    : ST_TRAIN;
        default:    st_d = ST_TRAIN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_TRAIN;
      pc_q <= '0;
    end else begin
      st_q <= st_d;
      pc_q <= pc_d;
    end
  end

  assign lock_o = force_ref_n && (st_q == ST_LOCK);
  assign trk_o  = force_ref_n && (st_q != ST_TRAIN);

  AST_FORCE_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !force_ref_n |=> (st_q == ST_TRAIN)); // R7
  AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK && $past(st_q) != ST_LOCK) |-> ($past(st_q) == ST_CONFIRM)); // R4
  AST_FAIL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ref_n && done_i && !pass_i && st_q != ST_TRAIN) |=> (st_q == ST_TRAIN)); // R5
  AST_PROBE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PROBE && $past(st_q) != ST_PROBE)
      |-> ($past(st_q) == ST_TRAIN && $past(pc_q) == PC_LAST)); // R6
  AST_HOLD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ref_n && !done_i) |=> $stable(st_q)); // R9
endmodule

// File: rtl/freq_lock_monitor.sv
`timescale 1ns/1ps
module freq_lock_monitor #(
  parameter int WIN_LOG2 = 15,
  parameter int TOL      = 3,
  parameter int POLL_REF = 4,
  parameter int DIV_FULL = 10,
  parameter int DIV_HALF = 20
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic rcv_clk,
  input  logic rate_half,
  input  logic force_ref_n,
  output logic lock,
  output logic trk_data
);
  localparam int CW = WIN_LOG2 + 2;

  logic          ref_rst_n, rcv_rst_n;
  logic [CW-1:0] gray_rcv, cnt_ref;
  logic          win_done, win_pass;

  flm_rst_sync u_rst_ref (.clk(clk_ref), .arst_n(rst_n), .srst_n(ref_rst_n));
  flm_rst_sync u_rst_rcv (.clk(rcv_clk), .arst_n(rst_n), .srst_n(rcv_rst_n));

  flm_tick_cnt #(.CW(CW), .DIV_FULL(DIV_FULL), .DIV_HALF(DIV_HALF)) u_tick (
    .clk(rcv_clk), .rst_n(rcv_rst_n), .rate_half(rate_half), .gray_o(gray_rcv)
  );

  flm_gray_sync #(.CW(CW)) u_xfer (
    .clk(clk_ref), .rst_n(ref_rst_n), .gray_i(gray_rcv), .bin_o(cnt_ref)
  );

  flm_window #(.WIN_LOG2(WIN_LOG2), .TOL(TOL), .CW(CW)) u_win (
    .clk(clk_ref), .rst_n(ref_rst_n), .cnt_i(cnt_ref),
    .done_o(win_done), .pass_o(win_pass)
  );

  flm_ctrl #(.POLL_REF(POLL_REF)) u_ctrl (
    .clk(clk_ref), .rst_n(ref_rst_n), .force_ref_n(force_ref_n),
    .done_i(win_done), .pass_i(win_pass), .lock_o(lock), .trk_o(trk_data)
  );

  AST_RESET_IDLE: assert property (@(posedge clk_ref) !ref_rst_n |-> (!lock && !trk_data)); // R1
endmodule

// File: tb/test_freq_lock_monitor.sv
`timescale 1ns/1ps
module test_freq_lock_monitor;
  localparam int WL   = 8;
  localparam int WIN  = 1 << WL;
  localparam int TOL  = 3;
  localparam int POLL = 4;

  logic clk_ref = 1'b0;
  logic rcv_clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_half = 1'b0;
  logic force_ref_n = 1'b1;
  logic lock, trk_data;
  real  hp = 0.5;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  int st = 0;
  int pc = 0;
  bit ok_prev = 1'b0;

  freq_lock_monitor #(.WIN_LOG2(WL), .TOL(TOL), .POLL_REF(POLL)) i_freq_lock_monitor (
    .clk_ref(clk_ref), .rst_n(rst_n), .rcv_clk(rcv_clk), .rate_half(rate_half),
    .force_ref_n(force_ref_n), .lock(lock), .trk_data(trk_data)
  );

  always #5 clk_ref = ~clk_ref;
  always #(hp) rcv_clk = ~rcv_clk;

  function automatic bit f_ok(real h, bit half);
    real c, d;
    c = WIN * 10.0 / (2.0 * h * (half ? 20.0 : 10.0));
    d = c - WIN;
    if (d < 0.0) d = -d;
    return d <= TOL;
  endfunction

  function automatic real f_hp(int idx, bit half);
    real base;
    base = half ? 0.25 : 0.5;
    case (idx)
      0, 1:    return base;
      2:       return base * 1.004;
      3:       return base * 0.996;
      4:       return base * 1.02;
      5:       return base * 0.98;
      default: return base * 1.1;
    endcase
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_out(string req, bit frc);
    chk(req, "lock", lock, (!frc && st == 3));
    chk(req, "trk_data", trk_data, (!frc && st != 0));
  endtask

  // Called at the drive point, two reference cycles before the window boundary.
  task automatic run_window(int w, real h, bit half, bit frc, string req);
    hp = h;
    rate_half = half;
    force_ref_n = !frc;
    if (frc) begin
      st = 0;
      pc = 0;
    end else if (w > 1) begin
      case (st)
        0: if (pc == POLL - 1) begin st = 1; pc = 0; end else pc++;
        1: st = ok_prev ? 2 : 0;
        2: st = ok_prev ? 3 : 0;
        default: if (!ok_prev) st = 0;
      endcase
    end
    ok_prev = f_ok(h, half);
    repeat (WIN / 4) @(posedge clk_ref);
    @(negedge clk_ref);
    check_out(req, frc);
    repeat (WIN / 2) @(posedge clk_ref);
    @(negedge clk_ref);
    check_out(req, frc);
    repeat (WIN / 4) @(posedge clk_ref);
    @(negedge clk_ref);
  endtask

  initial begin
    int w;
    void'($urandom(32'd2718));
    repeat (6) @(posedge clk_ref);
    @(negedge clk_ref);
    chk("R1", "lock in reset", lock, 1'b0);
    chk("R1", "trk_data in reset", trk_data, 1'b0);
    rst_n = 1'b1;
    w = 1;
    // R1 and R6: first training windows, then probe
    run_window(w++, 0.5, 1'b0, 1'b0, "R1");
    for (int i = 0; i < 4; i++) run_window(w++, 0.5, 1'b0, 1'b0, "R6");
    // R4: confirm then lock
    run_window(w++, 0.5, 1'b0, 1'b0, "R4");
    run_window(w++, 0.5, 1'b0, 1'b0, "R4");
    // R5: one failing window drops lock
    run_window(w++, 0.55, 1'b0, 1'b0, "R5");
    run_window(w++, 0.5, 1'b0, 1'b0, "R5");
    for (int i = 0; i < 3; i++) run_window(w++, 0.5, 1'b0, 1'b0, "R6");
    // R3: near-tolerance passes and a just-outside failure
    run_window(w++, 0.502, 1'b0, 1'b0, "R3");
    run_window(w++, 0.498, 1'b0, 1'b0, "R3");
    run_window(w++, 0.5, 1'b0, 1'b0, "R3");
    run_window(w++, 0.51, 1'b0, 1'b0, "R3");
    run_window(w++, 0.5, 1'b0, 1'b0, "R3");
    // R7: force, with the divide setting switched while forced
    run_window(w++, 0.5, 1'b0, 1'b1, "R7");
    run_window(w++, 0.25, 1'b1, 1'b1, "R7");
    // R2: half-rate divide locks, then a mismatched clock fails
    for (int i = 0; i < 6; i++) run_window(w++, 0.25, 1'b1, 1'b0, "R2");
    run_window(w++, 0.5, 1'b1, 1'b0, "R2");
    run_window(w++, 0.25, 1'b1, 1'b0, "R2");
    // R8: lock again through the gray crossing
    for (int i = 0; i < 6; i++) run_window(w++, 0.25, 1'b1, 1'b0, "R8");
    // R7: force while locked, switch back to full rate
    run_window(w++, 0.5, 1'b0, 1'b1, "R7");
    // R9: random frequencies and forces, full rate then half rate
    for (int blk = 0; blk < 2; blk++) begin
      bit half;
      half = (blk == 1);
      if (blk == 1) run_window(w++, 0.25, 1'b1, 1'b1, "R7");
      for (int i = 0; i < 60; i++) begin
        int idx;
        bit frc;
        idx = int'($urandom_range(0, 6));
        frc = ($urandom_range(0, 9) == 0);
        run_window(w++, f_hp(idx, half), half, frc, "R9");
      end
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(10.0 * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule